// File: doc/BRIEF.md
# Signed Word Divider with Defined Overflow

This unit divides one signed two's-complement word by another for a fixed-point execution pipeline. It returns a quotient truncated toward zero, an overflow flag, an updated summary-overflow bit and a four-bit condition field. When software asks for a recorded result, that field compares the quotient with zero. Operands are handed over with a valid/ready handshake. A single-cycle `done` pulse marks the cycle in which the results become valid. The results then stay fixed until the next operation is accepted.

Two operand pairs have no meaningful quotient: the most negative word divided by minus one, and any word divided by zero. The unit detects both as soon as the operands arrive. For both it returns the most negative word (only the MSB set) and reports "less than" in the condition field. The result is ready one cycle after acceptance. All other operand pairs go through a radix-2 restoring loop on the operand magnitudes, one quotient bit per clock, and a sign fix-up at the end.

Top module: `sdiv_unit`

## Requirements
- R1: For a nonzero divisor that is not the pair (most negative word, -1), the quotient equals the signed dividend divided by the signed divisor. It truncates toward zero, and its sign is the XOR of the operand signs.
- R2: The most negative word (only bit W-1 set) divided by all-ones (-1) gives a quotient of exactly the most negative word.
- R3: Any dividend divided by zero gives a quotient of exactly the most negative word.
- R4: For the R2 or R3 cases with `rec_en` high, `cr_field[3:1]` is 3'b100. Bit 3 is less-than, bit 2 is greater-than and bit 1 is equal. `cr_field[0]` equals `so_out`.
- R5: For the R1 case with `rec_en` high, `cr_field[3]` is set when the quotient is negative, `cr_field[2]` when it is positive, and `cr_field[1]` when it is zero. Exactly one of the three is set, and `cr_field[0]` equals `so_out`.
- R6: With `rec_en` low, `cr_field` is 4'b0000 after the operation.
- R7: `ov_out` equals `ov_en` AND (R2 or R3 case). `so_out` equals `so_in` OR `ov_out`.
- R8: Count the accepting clock edge as edge 1. `done` rises after edge 1 for the R2/R3 cases and after edge W+1 for all other operands. It stays high for one cycle only, unless a new special operation is accepted in that cycle.
- R9: While an operation is in the loop, `start_ready` is low. `start_valid` and new operands then have no effect on the result or its timing.
- R10: `quotient`, `cr_field`, `ov_out` and `so_out` change only when `done` rises. They hold their values from then until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Operands present and requesting a divide |
| start_ready | output | 1 | Unit idle and able to accept |
| dividend | input | W | Signed dividend |
| divisor | input | W | Signed divisor |
| rec_en | input | 1 | Record the condition field |
| ov_en | input | 1 | Enable overflow reporting |
| so_in | input | 1 | Current summary-overflow bit |
| quotient | output | W | Signed quotient |
| ov_out | output | 1 | Overflow flag |
| so_out | output | 1 | Updated summary-overflow bit |
| cr_field | output | 4 | {LT, GT, EQ, SO} |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong partial remainder or a stuck quotient bit in the loop shows up as a wrong quotient value on that operation's `done` cycle. It shows up as early as W+1 cycles after acceptance. A stale captured sign or record flag shows up in the same cycle, as a sign error or a condition field that contradicts the quotient. A miscounted iteration counter moves `done` by whole cycles, so the bench measures latency per operation. If the unit failed to ignore a busy-time request, the quotient on the next completion would belong to the wrong operand pair. The bench therefore sweeps every operand pair of a narrow instance and compares each result against plain integer division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} loop_state_t;
endpackage

// File: rtl/sdiv_classify.sv
module sdiv_classify #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         special,
  output logic         neg_q,
  output logic [W-1:0] num_mag,
  output logic [W-1:0] den_mag
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x);
    return x[W-1] ? (~x + 1'b1) : x;
  endfunction

  function automatic logic is_undefined(input logic [W-1:0] n, input logic [W-1:0] d);
    return (d == '0) || ((n == MINV) && (d == '1));
  endfunction

  always_comb begin
    special = is_undefined(dividend, divisor);
    neg_q   = dividend[W-1] ^ divisor[W-1];
    num_mag = magnitude(dividend);
    den_mag = magnitude(divisor);
  end
endmodule

// File: rtl/sdiv_mag_loop.sv
module sdiv_mag_loop
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] q_step
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  loop_state_t   st;
  logic [CW-1:0] cnt;
  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  den_r;
  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic          take;

  always_comb begin
    shifted = {rem[W-1:0], quo[W-1]};
    trial   = shifted - {1'b0, den_r};
    take    = ~trial[W];
    busy    = (st == ST_RUN);
    fin     = busy && (cnt == LAST);
    q_step  = {quo[W-2:0], take};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      rem   <= '0;
      quo   <= '0;
      den_r <= '0;
    end else if (load) begin
      st    <= ST_RUN;
      cnt   <= '0;
      rem   <= '0;
      quo   <= num;
      den_r <= den;
    end else if (busy) begin
      rem <= take ? trial : shifted;
      quo <= q_step;
      cnt <= cnt + CW'(1);
      if (fin) st <= ST_IDLE;
    end
  end

  a_r8_load_starts: assert property (@(posedge clk) disable iff (!rst_n) load |=> busy);
  a_r8_fin_ends: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !busy);
  a_r9_run_continues: assert property (@(posedge clk) disable iff (!rst_n) (busy && !fin) |=> busy);
endmodule

// File: rtl/sdiv_flags.sv
module sdiv_flags
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic signed [W-1:0] q,
  input  logic                special,
  input  logic                rec,
  input  logic                ov_en,
  input  logic                so_in,
  output logic [3:0]          cr,
  output logic                ov,
  output logic                so
);
  function automatic logic [3:0] cond_of(input logic signed [W-1:0] v,
                                         input logic sp, input logic r, input logic s);
    logic [3:0] c;
    c = '0;
    if (r) begin
      c[CR_SO] = s;
      if (sp) c[CR_LT] = 1'b1;
      else begin
        c[CR_LT] = (v < 0);
        c[CR_GT] = (v > 0);
        c[CR_EQ] = (v == 0);
      end
    end
    return c;
  endfunction

  always_comb begin
    ov = ov_en & special;
    so = so_in | ov;
    cr = cond_of(q, special, rec, so);
  end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  output logic         start_ready,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         rec_en,
  input  logic         ov_en,
  input  logic         so_in,
  output logic [W-1:0] quotient,
  output logic         ov_out,
  output logic         so_out,
  output logic [3:0]   cr_field,
  output logic         done
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic         special, neg_q, busy, fin, accept, spec_acc;
  logic [W-1:0] num_mag, den_mag, q_step, final_q, fl_q;
  logic         neg_r, rec_r, ov_r, so_r;
  logic         fl_sp, fl_rec, fl_ov, fl_so;
  logic [3:0]   fl_cr;
  logic         fl_ovo, fl_soo;

  sdiv_classify #(.W(W)) u_cls (
    .dividend(dividend), .divisor(divisor), .special(special),
    .neg_q(neg_q), .num_mag(num_mag), .den_mag(den_mag)
  );

  assign start_ready = !busy;
  assign accept      = start_valid && start_ready;
  assign spec_acc    = accept && special;

  sdiv_mag_loop #(.W(W)) u_loop (
    .clk(clk), .rst_n(rst_n), .load(accept && !special),
    .num(num_mag), .den(den_mag), .busy(busy), .fin(fin), .q_step(q_step)
  );

  always_comb begin
    final_q = neg_r ? (~q_step + 1'b1) : q_step;
    fl_q    = spec_acc ? MINV   : final_q;
    fl_sp   = spec_acc;
    fl_rec  = accept ? rec_en : rec_r;
    fl_ov   = accept ? ov_en  : ov_r;
    fl_so   = accept ? so_in  : so_r;
  end

  sdiv_flags #(.W(W)) u_flags (
    .q(fl_q), .special(fl_sp), .rec(fl_rec), .ov_en(fl_ov), .so_in(fl_so),
    .cr(fl_cr), .ov(fl_ovo), .so(fl_soo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_r    <= 1'b0;
      rec_r    <= 1'b0;
      ov_r     <= 1'b0;
      so_r     <= 1'b0;
      quotient <= '0;
      cr_field <= '0;
      ov_out   <= 1'b0;
      so_out   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        neg_r <= neg_q;
        rec_r <= rec_en;
        ov_r  <= ov_en;
        so_r  <= so_in;
      end
      if (spec_acc || fin) begin
        quotient <= fl_q;
        cr_field <= fl_cr;
        ov_out   <= fl_ovo;
        so_out   <= fl_soo;
        done     <= 1'b1;
      end
    end
  end

  a_r3_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && divisor == '0) |=> (done && quotient == MINV));
  a_r2_min_by_neg1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dividend == MINV && divisor == '1) |=> (done && quotient == MINV));
  a_r4_special_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && special && rec_en) |=> (cr_field[3:1] == 3'b100));
  a_r5_single_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cr_field[3:1]) <= 1);
  a_r7_ov_implies_so: assert property (@(posedge clk) disable iff (!rst_n)
    ov_out |-> so_out);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done);
  a_r9_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && busy && !fin) |=> !done);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_acc && !fin) |=> ($stable(quotient) && $stable(cr_field) && $stable(so_out)));
endmodule

// File: tb/sim_sdiv_unit.sv
module sim_sdiv_unit;
  localparam int  NW    = 6;
  localparam time TCLK  = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCLK/2) clk = ~clk;

  logic rec, ovn, soi;
  logic sv0 = 1'b0, sv1 = 1'b0;
  logic [NW-1:0] a0 = '0, b0 = '0, q0;
  logic [31:0]   a1 = '0, b1 = '0, q1;
  logic rdy0, rdy1, ov0, ov1, so0, so1, dn0, dn1;
  logic [3:0] cr0, cr1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  sdiv_unit #(.W(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(sv0), .start_ready(rdy0),
    .dividend(a0), .divisor(b0), .rec_en(rec), .ov_en(ovn), .so_in(soi),
    .quotient(q0), .ov_out(ov0), .so_out(so0), .cr_field(cr0), .done(dn0)
  );

  sdiv_unit #(.W(32)) u1 (
    .clk(clk), .rst_n(rst_n), .start_valid(sv1), .start_ready(rdy1),
    .dividend(a1), .divisor(b1), .rec_en(rec), .ov_en(ovn), .so_in(soi),
    .quotient(q1), .ov_out(ov1), .so_out(so1), .cr_field(cr1), .done(dn1)
  );

  function automatic longint sx(input longint v, input int n);
    longint m;
    m = (longint'(1) << n) - 1;
    v = v & m;
    if (((v >> (n - 1)) & 1) != 0) v = v - (longint'(1) << n);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int sel, input bit v, input longint a, input longint b);
    if (sel == 0) begin sv0 = v; a0 = a[NW-1:0]; b0 = b[NW-1:0]; end
    else          begin sv1 = v; a1 = a[31:0];   b1 = b[31:0];   end
  endtask

  task automatic run(input int sel, input longint a, input longint b,
                     input bit r, input bit o, input bit s, input bit junk, input bit hold);
    int nw, lat;
    longint sa, sb, eq, gq, minv;
    bit sp, e_ov, e_so, g_dn;
    logic [3:0] ecr, gcr, hcr;
    logic g_ov, g_so;
    string rq;
    nw   = (sel == 0) ? NW : 32;
    minv = -(longint'(1) << (nw - 1));
    sa = sx(a, nw);
    sb = sx(b, nw);
    sp = (sb == 0) || (sa == minv && sb == -1);
    eq = (sb == 0) ? minv : (sp ? minv : sa / sb);
    e_ov = o & sp;
    e_so = s | e_ov;
    if (!r) ecr = 4'b0000;
    else if (sp) ecr = {3'b100, e_so};
    else ecr = {eq < 0, eq > 0, eq == 0, e_so};
    rq = (sb == 0) ? "R3" : (sp ? "R2" : "R1");

    @(negedge clk);
    rec = r; ovn = o; soi = s;
    chk(((sel == 0) ? rdy0 : rdy1) == 1'b1, "R9 ready idle", 0, 1);
    drive(sel, 1'b1, a, b);
    @(posedge clk);
    @(negedge clk);
    drive(sel, 1'b0, a, b);
    lat = 1;
    if (!sp) chk(((sel == 0) ? rdy0 : rdy1) == 1'b0, "R9 ready busy", 1, 0);
    if (junk && !sp) begin
      drive(sel, 1'b1, ~a, b ^ 1);
      rec = ~r; ovn = 1'b1; soi = ~s;
    end
    g_dn = (sel == 0) ? dn0 : dn1;
    while (!g_dn && lat < 100) begin
      if (lat == 3) drive(sel, 1'b0, a, b);
      @(negedge clk);
      lat++;
      g_dn = (sel == 0) ? dn0 : dn1;
    end
    drive(sel, 1'b0, a, b);
    gq  = sx((sel == 0) ? longint'(q0) : longint'(q1), nw);
    gcr = (sel == 0) ? cr0 : cr1;
    g_ov = (sel == 0) ? ov0 : ov1;
    g_so = (sel == 0) ? so0 : so1;
    chk(gq == eq, rq, gq, eq);
    chk(gcr == ecr, r ? (sp ? "R4 cr" : "R5 cr") : "R6 cr", gcr, ecr);
    chk({g_ov, g_so} == {e_ov, e_so}, "R7 ov/so", {g_ov, g_so}, {e_ov, e_so});
    chk(lat == (sp ? 1 : nw + 1), "R8 latency", lat, sp ? 1 : nw + 1);
    if (hold) begin
      drive(sel, 1'b0, ~a, ~b);
      repeat (2) @(negedge clk);
      hcr = (sel == 0) ? cr0 : cr1;
      chk(((sel == 0) ? dn0 : dn1) == 1'b0, "R8 pulse", 1, 0);
      chk(sx((sel == 0) ? longint'(q0) : longint'(q1), nw) == eq && hcr == ecr,
          "R10 hold", sx((sel == 0) ? longint'(q0) : longint'(q1), nw), eq);
    end
  endtask

  initial begin
    rec = 1'b0; ovn = 1'b0; soi = 1'b0;
    repeat (3) @(negedge clk);
    chk(dn0 == 1'b0 && q0 == '0 && cr0 == '0 && ov0 == 1'b0, "reset outputs", q0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy0 == 1'b1 && rdy1 == 1'b1, "R9 reset ready", rdy0, 1);

    run(1, 64'h8000_0000, 64'hFFFF_FFFF, 1, 1, 0, 0, 1);
    run(1, 7, 0, 1, 0, 1, 0, 0);
    run(1, 123456, 0, 0, 1, 0, 0, 0);
    run(1, -7, 2, 1, 0, 0, 1, 1);
    run(1, 100, -7, 1, 1, 0, 0, 0);
    run(1, 64'h8000_0000, 2, 1, 0, 0, 0, 0);
    run(1, 0, 5, 1, 0, 1, 1, 0);
    run(1, 64'h7FFF_FFFF, 64'h8000_0000, 1, 0, 0, 0, 0);

    for (int i = 0; i < (1 << NW); i++) begin
      for (int j = 0; j < (1 << NW); j++) begin
        run(0, i, j, ((i + j) % 3) != 0, j[1], i[2], ((i ^ j) & 7) == 0, j == 5);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule